// File: doc/BRIEF.md
# Shared-Bus Arbiter Node with Host Handoff

This block decides, for one processor node on a shared external bus, when that node owns the bus. Up to eight nodes and one host share the bus. Every node drives one active-low request line and watches all eight. The node raises its line when its internal requester wants the bus, and it records which node currently owns the bus. That record follows a single rule that every node applies alike, so all nodes reach the same answer. The bus owner keeps the bus until it drops its line. When the bus is free, the lowest-numbered requesting node takes it.

The block also tracks the transaction that the node has issued, including its address and burst continuation, and decodes from that address whether the access goes to host space. A host asks for the bus with a request input. The owning node finishes its outstanding transfer, releases its line and raises the host grant. A back-off input can cut a host-space transfer short so that the host can take the bus at once. The abandoned transfer raises a retry flag, and the requester reissues it after the host has finished.

Top module: `mp_bus_arbiter`

## Requirements
- R1: The node's request is driven on `own_req_n` (active low), which the system wires to bus line number equal to the captured node ID (ID 3 drives line 3). `is_master` is 1 exactly when the registered owner is that line.
- R2: A bus line reads as requesting when it is 0. Lines held at 1, such as those of absent nodes, never request. When no owner holds the bus and no host request is pending, the lowest-numbered requesting line becomes owner at the next clock edge.
- R3: An owner keeps the bus while its line stays low, even when a lower-numbered line starts requesting. Ownership is re-evaluated only after the owner's line goes high.
- R4: `node_id` is captured once, on the first clock after reset is released. Later changes to `node_id` have no effect on which line is treated as the node's own.
- R5: `host_sel` is 1 when the node is master and bits 31:28 of `bus_addr` differ from 0b0000 (host space). It is combinational, so it follows `bus_addr` and `is_master` in the same cycle.
- R6: While `host_req` is 1, no new transaction is accepted and no new owner is chosen. The master keeps its line low until its outstanding transfer completes (`txn_done`), then releases the line. `host_grant` rises at the same edge that mastership ends, and it falls the edge after `host_req` returns to 0.
- R7: `backoff` while a host-space transfer is outstanding abandons the transfer. `own_req_n` goes high in that same cycle. At the next edge the transfer is no longer outstanding, `retry` is 1 and mastership ends. If `host_req` is 1, `host_grant` rises at that edge.
- R8: `backoff` while the outstanding transfer is outside host space has no effect: the transfer stays outstanding, and `retry` and mastership are unchanged.
- R9: A start accepted with `txn_burst`=1 ignores `txn_addr` and sets `bus_addr` to its previous value plus one. A start with `txn_burst`=0 loads `txn_addr`.
- R10: While reset is asserted, and until the ID is captured, `own_req_n` is 1, and `is_master`, `host_sel`, `host_grant`, `bus_lock`, `retry` and `bus_addr` are 0.
- R11: The next accepted start clears `retry`.
- R12: `bus_lock` is a register that becomes 1 at the edge after a cycle in which the node is master and `txn_lock` is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_id | input | 3 | Node number, captured after reset |
| bus_req_n | input | 8 | All eight bus request lines, active low |
| host_req | input | 1 | Host asks for the bus |
| backoff | input | 1 | Abandon an outstanding host-space transfer |
| txn_want | input | 1 | Internal requester wants the bus |
| txn_start | input | 1 | Start a transfer (accepted when master, idle, no host request) |
| txn_addr | input | 32 | Address of a non-burst transfer |
| txn_burst | input | 1 | Start continues a burst at address plus one |
| txn_done | input | 1 | Outstanding transfer completes |
| txn_lock | input | 1 | Requester locks the bus |
| own_req_n | output | 1 | This node's request line, active low |
| is_master | output | 1 | This node owns the bus |
| host_sel | output | 1 | Current address is in host space |
| host_grant | output | 1 | Bus handed to the host |
| bus_lock | output | 1 | Bus locked by this node |
| retry | output | 1 | An abandoned transfer must be reissued |
| bus_addr | output | 32 | Address of the current transfer |

## Verification
Registered results (`is_master`, `host_grant`, `bus_lock`, `retry`, `bus_addr`) are due at the first rising edge after the cycle in which the stimulus is applied. `own_req_n` and `host_sel` are combinational and already show the post-edge state in that cycle. The bench changes inputs on the falling edge and, for each step, queues the value expected once the next rising edge has passed. A monitor takes each entry off the queue 5 ns after that rising edge, so every check sees exactly one edge of effect. The handoff steps are chosen so that transfer completion, line release, owner change and grant each fall on known, separate edges.

// File: rtl/mp_arb_pkg.sv
package mp_arb_pkg;
  localparam int DEF_NODES  = 8;
  localparam int DEF_ADDR_W = 32;
  localparam int DEF_SEL_W  = 4;

  typedef struct packed {
    logic busy;
    logic retry;
  } txn_flags_t;
endpackage

// File: rtl/mp_rst_sync.sv
module mp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/mp_owner_track.sv
module mp_owner_track #(
  parameter int NODES = mp_arb_pkg::DEF_NODES,
  parameter int IDW   = $clog2(NODES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NODES-1:0] lines_n,
  input  logic             host_req,
  output logic             owner_valid,
  output logic [IDW-1:0]   owner_idx
);
  logic [NODES-1:0] req;
  logic             any_req;
  logic [IDW-1:0]   low_idx;
  logic             owner_valid_d, owner_valid_q;
  logic [IDW-1:0]   owner_idx_d, owner_idx_q;
  logic             owner_holds;

  assign req = ~lines_n;

  always_comb begin
    any_req = 1'b0;
    low_idx = '0;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (req[i]) begin
        any_req = 1'b1;
        low_idx = IDW'(i);
      end
    end
  end

  assign owner_holds = owner_valid_q && req[owner_idx_q];

  always_comb begin
    owner_valid_d = owner_valid_q;
    owner_idx_d   = owner_idx_q;
    if (!owner_holds) begin
      if (!host_req && any_req) begin
        owner_valid_d = 1'b1;
        owner_idx_d   = low_idx;
      end else begin
        owner_valid_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_valid_q <= 1'b0;
      owner_idx_q   <= '0;
    end else begin
      owner_valid_q <= owner_valid_d;
      owner_idx_q   <= owner_idx_d;
    end
  end

  assign owner_valid = owner_valid_q;
  assign owner_idx   = owner_idx_q;

  assert_owner_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_valid_q && req[owner_idx_q]) |=> (owner_valid_q && $stable(owner_idx_q)));

  assert_host_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!owner_valid_q && host_req) |=> !owner_valid_q);
endmodule

// File: rtl/mp_txn_track.sv
module mp_txn_track #(
  parameter int ADDR_W = mp_arb_pkg::DEF_ADDR_W,
  parameter int SEL_W  = mp_arb_pkg::DEF_SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic              txn_burst,
  input  logic              txn_done,
  input  logic              backoff,
  output logic              busy,
  output logic              retry,
  output logic              abort,
  output logic              host_space,
  output logic [ADDR_W-1:0] addr
);
  import mp_arb_pkg::*;

  localparam int SEL_LO = ADDR_W - SEL_W;

  txn_flags_t        flags_d, flags_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic              addr_en;

  assign host_space = (addr_q[ADDR_W-1:SEL_LO] != '0);
  assign abort      = backoff && flags_q.busy && host_space;
  assign addr_en    = accept;

  always_comb begin
    flags_d = flags_q;
    addr_d  = addr_q;
    if (abort) begin
      flags_d.busy  = 1'b0;
      flags_d.retry = 1'b1;
    end else if (accept) begin
      flags_d.busy  = 1'b1;
      flags_d.retry = 1'b0;
      addr_d        = txn_burst ? addr_q + ADDR_W'(1) : txn_addr;
    end else if (txn_done && flags_q.busy) begin
      flags_d.busy  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign busy  = flags_q.busy;
  assign retry = flags_q.retry;
  assign addr  = addr_q;

  assert_abort_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && retry));

  assert_boff_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (backoff && busy && !host_space && !txn_done) |=> busy);

  assert_burst_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && txn_burst) |=> (addr == $past(addr) + ADDR_W'(1)));

  assert_retry_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !retry);
endmodule

// File: rtl/mp_bus_arbiter.sv
module mp_bus_arbiter #(
  parameter int NODES  = mp_arb_pkg::DEF_NODES,
  parameter int ADDR_W = mp_arb_pkg::DEF_ADDR_W,
  parameter int SEL_W  = mp_arb_pkg::DEF_SEL_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(NODES)-1:0] node_id,
  input  logic [NODES-1:0]         bus_req_n,
  input  logic                     host_req,
  input  logic                     backoff,
  input  logic                     txn_want,
  input  logic                     txn_start,
  input  logic [ADDR_W-1:0]        txn_addr,
  input  logic                     txn_burst,
  input  logic                     txn_done,
  input  logic                     txn_lock,
  output logic                     own_req_n,
  output logic                     is_master,
  output logic                     host_sel,
  output logic                     host_grant,
  output logic                     bus_lock,
  output logic                     retry,
  output logic [ADDR_W-1:0]        bus_addr
);
  localparam int IDW = $clog2(NODES);

  logic           rst_s_n;
  logic           id_ok_q, id_ok_d;
  logic [IDW-1:0] id_q, id_d;
  logic           id_en;
  logic           owner_valid;
  logic [IDW-1:0] owner_idx;
  logic           master;
  logic           accept;
  logic           busy, abort, host_space;
  logic           grant_d, grant_q;
  logic           lock_d, lock_q;
  logic           req_on;

  mp_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  assign id_en   = !id_ok_q;
  assign id_d    = node_id;
  assign id_ok_d = 1'b1;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      id_ok_q <= 1'b0;
      id_q    <= '0;
    end else if (id_en) begin
      id_ok_q <= id_ok_d;
      id_q    <= id_d;
    end
  end

  mp_owner_track #(.NODES(NODES), .IDW(IDW)) i_owner (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .lines_n     (bus_req_n),
    .host_req    (host_req),
    .owner_valid (owner_valid),
    .owner_idx   (owner_idx)
  );

  assign master = id_ok_q && owner_valid && (owner_idx == id_q);
  assign accept = master && txn_start && !busy && !host_req;

  mp_txn_track #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) i_txn (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .accept     (accept),
    .txn_addr   (txn_addr),
    .txn_burst  (txn_burst),
    .txn_done   (txn_done),
    .backoff    (backoff),
    .busy       (busy),
    .retry      (retry),
    .abort      (abort),
    .host_space (host_space),
    .addr       (bus_addr)
  );

  assign req_on = id_ok_q && txn_want && !(host_req && !busy) && !abort;

  always_comb begin
    grant_d = 1'b0;
    if (host_req) begin
      grant_d = grant_q
             || (master && (!busy || abort))
             || (id_ok_q && !owner_valid && (id_q == '0));
    end
  end

  assign lock_d = master && txn_lock;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      grant_q <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      grant_q <= grant_d;
      lock_q  <= lock_d;
    end
  end

  assign own_req_n  = !req_on;
  assign is_master  = master;
  assign host_sel   = master && host_space;
  assign host_grant = grant_q;
  assign bus_lock   = lock_q;

  assert_grant_excl_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    grant_q |-> !master);

  assert_grant_idle_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(grant_q) |-> !busy);

  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    !id_ok_q |-> (own_req_n && !is_master && !grant_q));
endmodule

// File: tb/test_mp_bus_arbiter.sv
module test_mp_bus_arbiter;
  localparam int MY_ID = 3;

  typedef struct {
    string       tag;
    logic [37:0] val;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  node_id;
  logic [7:0]  oth_n;
  logic [7:0]  bus_req_n;
  logic        host_req, backoff, txn_want, txn_start, txn_burst, txn_done, txn_lock;
  logic [31:0] txn_addr;
  logic        own_req_n, is_master, host_sel, host_grant, bus_lock, retry;
  logic [31:0] bus_addr;

  int   total = 0;
  int   bad   = 0;
  bit   done_flag = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  assign bus_req_n = {oth_n[7:4], own_req_n, oth_n[2:0]};

  mp_bus_arbiter i_mp_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .node_id(node_id), .bus_req_n(bus_req_n),
    .host_req(host_req), .backoff(backoff), .txn_want(txn_want),
    .txn_start(txn_start), .txn_addr(txn_addr), .txn_burst(txn_burst),
    .txn_done(txn_done), .txn_lock(txn_lock), .own_req_n(own_req_n),
    .is_master(is_master), .host_sel(host_sel), .host_grant(host_grant),
    .bus_lock(bus_lock), .retry(retry), .bus_addr(bus_addr)
  );

  function automatic logic [37:0] pack(logic rq, logic m, logic hs, logic hg,
                                       logic lk, logic rt, logic [31:0] a);
    return {rq, m, hs, hg, lk, rt, a};
  endfunction

  function automatic logic [37:0] actual();
    return {own_req_n, is_master, host_sel, host_grant, bus_lock, retry, bus_addr};
  endfunction

  task automatic check(string tag, logic [37:0] act, logic [37:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic want, logic lock, logic start,
                      logic [31:0] addr, logic burst, logic dn, logic boff,
                      logic hreq, logic [7:0] others, logic [37:0] exp);
    exp_t e;
    @(negedge clk);
    txn_want = want; txn_lock = lock; txn_start = start; txn_addr = addr;
    txn_burst = burst; txn_done = dn; backoff = boff; host_req = hreq;
    oth_n = others;
    e.tag = tag; e.val = exp;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(e.tag, actual(), e.val);
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    rst_n = 1'b0; node_id = 3'(MY_ID); oth_n = 8'hFF;
    host_req = 0; backoff = 0; txn_want = 0; txn_start = 0; txn_addr = '0;
    txn_burst = 0; txn_done = 0; txn_lock = 0;
    repeat (3) @(posedge clk);
    #5;
    // R10: outputs inactive while reset is held
    check("R10 reset", actual(), pack(1, 0, 0, 0, 0, 0, 32'h0));
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R10: still quiet when idle after ID capture
    check("R10 idle", actual(), pack(1, 0, 0, 0, 0, 0, 32'h0));

    // R1/R2: own line 3 requesting, others absent (high) -> master
    step("R1 own line wins", 1, 0, 0, 32'h0, 0, 0, 0, 0, 8'hFF, pack(0, 1, 0, 0, 0, 0, 32'h0));
    // R3: line 1 begins requesting, owner keeps bus
    step("R3 hold vs lower", 1, 0, 0, 32'h0, 0, 0, 0, 0, 8'hFD, pack(0, 1, 0, 0, 0, 0, 32'h0));
    // R5: host-space address (top nibble 2)
    step("R5 host sel", 1, 0, 1, 32'h2000_0010, 0, 0, 0, 0, 8'hFD, pack(0, 1, 1, 0, 0, 0, 32'h2000_0010));
    step("R5 done", 1, 0, 0, 32'h0, 0, 1, 0, 0, 8'hFD, pack(0, 1, 1, 0, 0, 0, 32'h2000_0010));
    // R9: burst continuation ignores txn_addr, increments
    step("R9 burst inc", 1, 0, 1, 32'hFFFF_FFFF, 1, 0, 0, 0, 8'hFD, pack(0, 1, 1, 0, 0, 0, 32'h2000_0011));
    step("R9 burst done", 1, 0, 0, 32'h0, 0, 1, 0, 0, 8'hFD, pack(0, 1, 1, 0, 0, 0, 32'h2000_0011));
    // R5: non-host address (top nibble 0)
    step("R5 local addr", 1, 0, 1, 32'h0000_0100, 0, 0, 0, 0, 8'hFD, pack(0, 1, 0, 0, 0, 0, 32'h0000_0100));
    // R8: backoff on local transfer ignored
    step("R8 boff ignored", 1, 0, 0, 32'h0, 0, 0, 1, 0, 8'hFD, pack(0, 1, 0, 0, 0, 0, 32'h0000_0100));
    // R6/R8: host request waits on still-outstanding transfer
    step("R6 wait busy", 1, 0, 0, 32'h0, 0, 0, 0, 1, 8'hFD, pack(0, 1, 0, 0, 0, 0, 32'h0000_0100));
    step("R6 done release", 1, 0, 0, 32'h0, 0, 1, 0, 1, 8'hFD, pack(1, 1, 0, 0, 0, 0, 32'h0000_0100));
    step("R6 grant", 1, 0, 0, 32'h0, 0, 0, 0, 1, 8'hFD, pack(1, 0, 0, 1, 0, 0, 32'h0000_0100));
    // R2: host gone, free bus goes to lowest requester (line 1)
    step("R2 lowest wins", 1, 0, 0, 32'h0, 0, 0, 0, 0, 8'hFD, pack(0, 0, 0, 0, 0, 0, 32'h0000_0100));
    step("R2 line1 drops", 1, 0, 0, 32'h0, 0, 0, 0, 0, 8'hFF, pack(0, 1, 0, 0, 0, 0, 32'h0000_0100));
    step("R5 host addr 3", 1, 0, 1, 32'h3000_0000, 0, 0, 0, 0, 8'hFF, pack(0, 1, 1, 0, 0, 0, 32'h3000_0000));
    // R7: backoff on host-space transfer aborts, host granted
    step("R7 abort", 1, 0, 0, 32'h0, 0, 0, 1, 1, 8'hFF, pack(1, 0, 0, 1, 0, 1, 32'h3000_0000));
    step("R7 regain", 1, 0, 0, 32'h0, 0, 0, 0, 0, 8'hFF, pack(0, 1, 1, 0, 0, 1, 32'h3000_0000));
    // R11/R12: reissue clears retry; lock registered
    step("R11 R12 reissue lock", 1, 1, 1, 32'h0000_0040, 0, 0, 0, 0, 8'hFF, pack(0, 1, 0, 0, 1, 0, 32'h0000_0040));
    step("R12 unlock", 1, 0, 0, 32'h0, 0, 1, 0, 0, 8'hFF, pack(0, 1, 0, 0, 0, 0, 32'h0000_0040));
    step("R3 release", 0, 0, 0, 32'h0, 0, 0, 0, 0, 8'hFF, pack(1, 0, 0, 0, 0, 0, 32'h0000_0040));
    // R4: new node_id value ignored, line 3 still ours
    @(negedge clk); node_id = 3'd5;
    step("R4 id frozen", 1, 0, 0, 32'h0, 0, 0, 0, 0, 8'hFF, pack(0, 1, 0, 0, 0, 0, 32'h0000_0040));

    repeat (3) @(negedge clk);
    if (!done_flag) begin
      done_flag = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule